// File: doc/BRIEF.md
# Handshaked DMA Transfer Engine

This engine moves data for up to four programmed channels, one at a time, over a single-beat memory master port. A register file outside the block holds each channel's settings (start flag, source and destination addresses, element count, element width, address steps, handshake line numbers and finish-flag enable). The engine reads those settings and sends back updated addresses, the remaining count and completion through a one-cycle write-back strobe.

Each burst moves one element, or up to four. Every element of the burst is read into a small internal buffer before any of them is written. A channel can be tied to peripheral request lines, one for its source and one for its destination. The engine starts a burst only when those lines show the peripheral is ready. It raises the matching acknowledge when its side of the burst is done, and holds that acknowledge until the peripheral drops its request. A channel that is not ready is passed over, so a lower-priority channel that is ready can use the engine.

Top module: `hs_dma_engine`

## Requirements
- R1: Only one channel is active at a time. After every burst the engine grants the lowest-numbered channel that is started and eligible.
- R2: A channel is eligible when its count is zero or when each nonzero handshake number it uses names a request line that is high with its acknowledge low. Handshake number 0 means no handshake is used.
- R3: When the burst flag is set, a burst moves four elements, or the remaining count if that is smaller. When the flag is clear, a burst moves one element. The count drops by the number of elements moved, and there is one write-back per burst.
- R4: All reads of a burst complete before the first write of that burst.
- R5: The source acknowledge rises in the cycle after the burst's last read completes. The destination acknowledge rises in the cycle after its last write completes.
- R6: An acknowledge stays high while its request is high and is low in the cycle after the request is sampled low.
- R7: The width code selects 1 byte (code 0), 2 bytes (code 1) or 4 bytes (codes 2 and 3). The step code keeps the address fixed (code 0) or advances it by 1, 2 or 4 elements (codes 1, 2, 3) after each element.
- R8: The write-back that brings the count to zero marks the channel done, which clears its start flag. It sets the finish flag only when finish enable is set.
- R9: Each write-back carries the channel's current source address, destination address and count, so the register file holds the final addresses when the channel stops.
- R10: A channel that is not eligible does not block later channels, and it runs once its lines become ready.
- R11: A channel started with count zero completes with no memory access.
- R12: After reset all acknowledges are low, and there is no memory request and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_start_i | input | NCH | Start flag for each channel |
| ch_src_addr_i | input | NCH*AW | Source address for each channel |
| ch_dst_addr_i | input | NCH*AW | Destination address for each channel |
| ch_count_i | input | NCH*CW | Remaining element count for each channel |
| ch_burst_i | input | NCH | Burst flag: 1 means four-element bursts |
| ch_width_i | input | NCH*2 | Element width code |
| ch_src_step_i | input | NCH*2 | Source step code |
| ch_dst_step_i | input | NCH*2 | Destination step code |
| ch_src_hs_i | input | NCH*HSW | Source request line number, 0 for none |
| ch_dst_hs_i | input | NCH*HSW | Destination request line number, 0 for none |
| ch_fin_en_i | input | NCH | Finish flag enable |
| dreq_i | input | NHS | Peripheral request lines (bit 0 unused) |
| dack_o | output | NHS | Peripheral acknowledge lines |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Byte address |
| mem_size_o | output | 2 | Width code of the access |
| mem_wdata_o | output | DW | Write data, right-aligned |
| mem_rdata_i | input | DW | Read data, right-aligned |
| mem_ready_i | input | 1 | Access completes in this cycle |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_ch_o | output | CHW | Channel being written back |
| wb_src_o | output | AW | Updated source address |
| wb_dst_o | output | AW | Updated destination address |
| wb_count_o | output | CW | Updated remaining count |
| wb_done_o | output | 1 | Channel finished, clear its start flag |
| wb_fin_o | output | 1 | Set the channel's finish flag |

## Verification
Some properties are checked on every cycle. The grant is never given to more than one channel. A burst's first read is never issued unless the handshake lines it uses were high. No read follows a write within a burst. An acknowledge always falls after its request falls. The finish flag is never set without done. The bench scenarios cover what needs a whole transfer to see: data copied with each width and step code, burst splitting at the end of the count, when each acknowledge rises, a channel that stays blocked while its acknowledges are held, the order of service between a blocked channel and ready ones, and completion with a zero count.

// File: rtl/hs_dma_pkg.sv
package hs_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_WB} dma_state_e;

  function automatic logic [3:0] elem_bytes(input logic [1:0] w);
    case (w)
      2'd0:    elem_bytes = 4'd1;
      2'd1:    elem_bytes = 4'd2;
      default: elem_bytes = 4'd4;
    endcase
  endfunction

  // step code 0: fixed; 1/2/3: advance by 1/2/4 elements
  function automatic logic [4:0] step_bytes(input logic [1:0] w, input logic [1:0] code);
    if (code == 2'd0) step_bytes = 5'd0;
    else              step_bytes = {1'b0, elem_bytes(w)} << (code - 2'd1);
  endfunction
endpackage

// File: rtl/hs_dma_sched.sv
module hs_dma_sched #(
  parameter int NCH = 4,
  parameter int NHS = 16,
  parameter int CW  = 24,
  localparam int CHW = $clog2(NCH),
  localparam int HSW = $clog2(NHS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCH-1:0]     start_i,
  input  logic [NCH*CW-1:0]  count_i,
  input  logic [NCH*HSW-1:0] src_hs_i,
  input  logic [NCH*HSW-1:0] dst_hs_i,
  input  logic [NHS-1:0]     dreq_i,
  input  logic [NHS-1:0]     dack_i,
  output logic               valid_o,
  output logic [CHW-1:0]     sel_o,
  output logic [NCH-1:0]     grant_o
);
  logic [NCH-1:0] elig;

  for (genvar c = 0; c < NCH; c++) begin : g_elig
    logic [HSW-1:0] s_id, d_id;
    logic           s_ok, d_ok;
    assign s_id = src_hs_i[c*HSW +: HSW];
    assign d_id = dst_hs_i[c*HSW +: HSW];
    assign s_ok = (s_id == '0) || (dreq_i[s_id] && !dack_i[s_id]);
    assign d_ok = (d_id == '0) || (dreq_i[d_id] && !dack_i[d_id]);
    assign elig[c] = start_i[c] && ((count_i[c*CW +: CW] == '0) || (s_ok && d_ok));
  end

  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (elig[c]) begin
        valid_o = 1'b1;
        sel_o   = CHW'(c);
      end
    end
  end

  assign grant_o = valid_o ? (NCH'(1) << sel_o) : '0;

  a_r1_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
endmodule

// File: rtl/hs_dma_ack.sv
module hs_dma_ack #(
  parameter int NHS = 16,
  localparam int HSW = $clog2(NHS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NHS-1:0] dreq_i,
  input  logic           src_set_i,
  input  logic [HSW-1:0] src_id_i,
  input  logic           dst_set_i,
  input  logic [HSW-1:0] dst_id_i,
  output logic [NHS-1:0] dack_o
);
  assign dack_o[0] = 1'b0;

  for (genvar k = 1; k < NHS; k++) begin : g_line
    logic set_k;
    assign set_k = (src_set_i && src_id_i == HSW'(k)) || (dst_set_i && dst_id_i == HSW'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dack_o[k] <= 1'b0;
      else         dack_o[k] <= dreq_i[k] && (dack_o[k] || set_k);
    end

    a_r6_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dreq_i[k] |=> !dack_o[k]);
  end
endmodule

// File: rtl/hs_dma_mover.sv
module hs_dma_mover
  import hs_dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NHS  = 16,
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int DW   = 32,
  parameter int BMAX = 4,
  localparam int CHW = $clog2(NCH),
  localparam int HSW = $clog2(NHS),
  localparam int NW  = $clog2(BMAX + 1),
  localparam int IW  = $clog2(BMAX)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sel_valid_i,
  input  logic [CHW-1:0] sel_ch_i,
  input  logic [AW-1:0]  sel_src_i,
  input  logic [AW-1:0]  sel_dst_i,
  input  logic [CW-1:0]  sel_count_i,
  input  logic           sel_burst_i,
  input  logic [1:0]     sel_width_i,
  input  logic [1:0]     sel_src_step_i,
  input  logic [1:0]     sel_dst_step_i,
  input  logic [HSW-1:0] sel_src_hs_i,
  input  logic [HSW-1:0] sel_dst_hs_i,
  input  logic           sel_fin_en_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [1:0]     mem_size_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i,
  output logic           src_set_o,
  output logic           dst_set_o,
  output logic [HSW-1:0] src_hs_o,
  output logic [HSW-1:0] dst_hs_o,
  output logic           wb_valid_o,
  output logic [CHW-1:0] wb_ch_o,
  output logic [AW-1:0]  wb_src_o,
  output logic [AW-1:0]  wb_dst_o,
  output logic [CW-1:0]  wb_count_o,
  output logic           wb_done_o,
  output logic           wb_fin_o
);
  dma_state_e     st_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [CW-1:0]  cnt_q;
  logic [1:0]     wid_q;
  logic [4:0]     sstep_q, dstep_q;
  logic           fen_q;
  logic [NW-1:0]  n_q, idx_q;
  logic [DW-1:0]  buf_q [BMAX];
  logic           last;
  logic [NW-1:0]  n_new;

  assign last  = (idx_q == n_q - NW'(1));
  assign n_new = !sel_burst_i ? NW'(1) :
                 (sel_count_i < CW'(BMAX)) ? NW'(sel_count_i) : NW'(BMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ch_q     <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      wid_q    <= '0;
      sstep_q  <= '0;
      dstep_q  <= '0;
      src_hs_o <= '0;
      dst_hs_o <= '0;
      fen_q    <= 1'b0;
      n_q      <= '0;
      idx_q    <= '0;
      for (int i = 0; i < BMAX; i++) buf_q[i] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (sel_valid_i) begin
          ch_q     <= sel_ch_i;
          src_q    <= sel_src_i;
          dst_q    <= sel_dst_i;
          cnt_q    <= sel_count_i;
          wid_q    <= sel_width_i;
          sstep_q  <= step_bytes(sel_width_i, sel_src_step_i);
          dstep_q  <= step_bytes(sel_width_i, sel_dst_step_i);
          src_hs_o <= sel_src_hs_i;
          dst_hs_o <= sel_dst_hs_i;
          fen_q    <= sel_fin_en_i;
          n_q      <= n_new;
          idx_q    <= '0;
          st_q     <= (sel_count_i == '0) ? ST_WB : ST_READ;
        end
        ST_READ: if (mem_ready_i) begin
          buf_q[idx_q[IW-1:0]] <= mem_rdata_i;
          src_q <= src_q + AW'(sstep_q);
          if (last) begin
            idx_q <= '0;
            st_q  <= ST_WRITE;
          end else idx_q <= idx_q + NW'(1);
        end
        ST_WRITE: if (mem_ready_i) begin
          dst_q <= dst_q + AW'(dstep_q);
          if (last) begin
            cnt_q <= cnt_q - CW'(n_q);
            st_q  <= ST_WB;
          end else idx_q <= idx_q + NW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we_o    = (st_q == ST_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_q : src_q;
  assign mem_size_o  = wid_q;
  assign mem_wdata_o = buf_q[idx_q[IW-1:0]];

  assign src_set_o = (st_q == ST_READ)  && mem_ready_i && last;
  assign dst_set_o = (st_q == ST_WRITE) && mem_ready_i && last;

  assign wb_valid_o = (st_q == ST_WB);
  assign wb_ch_o    = ch_q;
  assign wb_src_o   = src_q;
  assign wb_dst_o   = dst_q;
  assign wb_count_o = cnt_q;
  assign wb_done_o  = wb_valid_o && (cnt_q == '0);
  assign wb_fin_o   = wb_done_o && fen_q;

  a_r4_no_read_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> !(mem_req_o && !mem_we_o));
  a_r8_fin_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_fin_o |-> (wb_done_o && wb_valid_o));
endmodule

// File: rtl/hs_dma_engine.sv
module hs_dma_engine #(
  parameter int NCH  = 4,
  parameter int NHS  = 16,
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int DW   = 32,
  parameter int BMAX = 4,
  localparam int CHW = $clog2(NCH),
  localparam int HSW = $clog2(NHS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCH-1:0]     ch_start_i,
  input  logic [NCH*AW-1:0]  ch_src_addr_i,
  input  logic [NCH*AW-1:0]  ch_dst_addr_i,
  input  logic [NCH*CW-1:0]  ch_count_i,
  input  logic [NCH-1:0]     ch_burst_i,
  input  logic [NCH*2-1:0]   ch_width_i,
  input  logic [NCH*2-1:0]   ch_src_step_i,
  input  logic [NCH*2-1:0]   ch_dst_step_i,
  input  logic [NCH*HSW-1:0] ch_src_hs_i,
  input  logic [NCH*HSW-1:0] ch_dst_hs_i,
  input  logic [NCH-1:0]     ch_fin_en_i,
  input  logic [NHS-1:0]     dreq_i,
  output logic [NHS-1:0]     dack_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [1:0]         mem_size_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic               mem_ready_i,
  output logic               wb_valid_o,
  output logic [CHW-1:0]     wb_ch_o,
  output logic [AW-1:0]      wb_src_o,
  output logic [AW-1:0]      wb_dst_o,
  output logic [CW-1:0]      wb_count_o,
  output logic               wb_done_o,
  output logic               wb_fin_o
);
  logic           sel_valid;
  logic [CHW-1:0] sel;
  logic [NCH-1:0] grant;
  logic           src_set, dst_set;
  logic [HSW-1:0] src_hs, dst_hs;
  logic           idle_ok;

  // the grant only matters while the mover is idle (no request, no write-back)
  assign idle_ok = !mem_req_o && !wb_valid_o;

  hs_dma_sched #(.NCH(NCH), .NHS(NHS), .CW(CW)) u_sched (
    .clk_i, .rst_ni,
    .start_i (ch_start_i),
    .count_i (ch_count_i),
    .src_hs_i(ch_src_hs_i),
    .dst_hs_i(ch_dst_hs_i),
    .dreq_i,
    .dack_i  (dack_o),
    .valid_o (sel_valid),
    .sel_o   (sel),
    .grant_o (grant)
  );

  hs_dma_mover #(.NCH(NCH), .NHS(NHS), .AW(AW), .CW(CW), .DW(DW), .BMAX(BMAX)) u_mover (
    .clk_i, .rst_ni,
    .sel_valid_i   (sel_valid && idle_ok),
    .sel_ch_i      (sel),
    .sel_src_i     (ch_src_addr_i[sel*AW +: AW]),
    .sel_dst_i     (ch_dst_addr_i[sel*AW +: AW]),
    .sel_count_i   (ch_count_i[sel*CW +: CW]),
    .sel_burst_i   (ch_burst_i[sel]),
    .sel_width_i   (ch_width_i[sel*2 +: 2]),
    .sel_src_step_i(ch_src_step_i[sel*2 +: 2]),
    .sel_dst_step_i(ch_dst_step_i[sel*2 +: 2]),
    .sel_src_hs_i  (ch_src_hs_i[sel*HSW +: HSW]),
    .sel_dst_hs_i  (ch_dst_hs_i[sel*HSW +: HSW]),
    .sel_fin_en_i  (ch_fin_en_i[sel]),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_size_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i,
    .src_set_o (src_set),
    .dst_set_o (dst_set),
    .src_hs_o  (src_hs),
    .dst_hs_o  (dst_hs),
    .wb_valid_o, .wb_ch_o, .wb_src_o, .wb_dst_o, .wb_count_o, .wb_done_o, .wb_fin_o
  );

  hs_dma_ack #(.NHS(NHS)) u_ack (
    .clk_i, .rst_ni,
    .dreq_i,
    .src_set_i(src_set),
    .src_id_i (src_hs),
    .dst_set_i(dst_set),
    .dst_id_i (dst_hs),
    .dack_o
  );

  logic [NHS-1:0] dreq_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dreq_d <= '0;
    else         dreq_d <= dreq_i;
  end

  a_r2_src_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !mem_we_o) |-> (src_hs == '0 || dreq_d[src_hs]));
  a_r2_dst_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !mem_we_o) |-> (dst_hs == '0 || dreq_d[dst_hs]));
  a_r1_grant_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant != '0) |-> sel_valid);
endmodule

// File: tb/sim_hs_dma_engine.sv
module sim_hs_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, NHS = 16, AW = 32, CW = 24, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NCH-1:0] ch_start, ch_burst, ch_fin_en;
  logic [NCH*AW-1:0] ch_src, ch_dst;
  logic [NCH*CW-1:0] ch_cnt;
  logic [NCH*2-1:0] ch_wid, ch_ss, ch_ds;
  logic [NCH*4-1:0] ch_shs, ch_dhs;
  logic [NHS-1:0] dreq, dack;
  logic mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic wb_valid, wb_done, wb_fin;
  logic [1:0] wb_ch;
  logic [AW-1:0] wb_src, wb_dst;
  logic [CW-1:0] wb_cnt;

  // register file model
  logic rf_st [NCH], rf_b4 [NCH], rf_fen [NCH], rf_fin [NCH];
  logic [AW-1:0] rf_src [NCH], rf_dst [NCH];
  logic [CW-1:0] rf_cnt [NCH];
  logic [1:0] rf_wid [NCH], rf_ss [NCH], rf_ds [NCH];
  logic [3:0] rf_shs [NCH], rf_dhs [NCH];
  logic [7:0] mem [1024];
  int rd_n = 0, wr_n = 0, wb_n = 0;
  int wb_log [64];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_start[c] = rf_st[c];
      ch_burst[c] = rf_b4[c];
      ch_fin_en[c] = rf_fen[c];
      ch_src[c*AW +: AW] = rf_src[c];
      ch_dst[c*AW +: AW] = rf_dst[c];
      ch_cnt[c*CW +: CW] = rf_cnt[c];
      ch_wid[c*2 +: 2] = rf_wid[c];
      ch_ss[c*2 +: 2] = rf_ss[c];
      ch_ds[c*2 +: 2] = rf_ds[c];
      ch_shs[c*4 +: 4] = rf_shs[c];
      ch_dhs[c*4 +: 4] = rf_dhs[c];
    end
  end

  always_comb mem_rdata = {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                           mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata[7:0];
        if (mem_size != 2'd0) mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
        if (mem_size[1]) begin
          mem[mem_addr[9:0] + 10'd2] <= mem_wdata[23:16];
          mem[mem_addr[9:0] + 10'd3] <= mem_wdata[31:24];
        end
        wr_n <= wr_n + 1;
      end else rd_n <= rd_n + 1;
    end
    if (rst_n && wb_valid) begin
      rf_src[wb_ch] <= wb_src;
      rf_dst[wb_ch] <= wb_dst;
      rf_cnt[wb_ch] <= wb_cnt;
      if (wb_done) rf_st[wb_ch] <= 1'b0;
      if (wb_fin) rf_fin[wb_ch] <= 1'b1;
      wb_log[wb_n % 64] <= int'(wb_ch);
      wb_n <= wb_n + 1;
    end
  end

  hs_dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ch_start_i(ch_start), .ch_src_addr_i(ch_src), .ch_dst_addr_i(ch_dst),
    .ch_count_i(ch_cnt), .ch_burst_i(ch_burst), .ch_width_i(ch_wid),
    .ch_src_step_i(ch_ss), .ch_dst_step_i(ch_ds), .ch_src_hs_i(ch_shs),
    .ch_dst_hs_i(ch_dhs), .ch_fin_en_i(ch_fin_en),
    .dreq_i(dreq), .dack_o(dack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready),
    .wb_valid_o(wb_valid), .wb_ch_o(wb_ch), .wb_src_o(wb_src), .wb_dst_o(wb_dst),
    .wb_count_o(wb_cnt), .wb_done_o(wb_done), .wb_fin_o(wb_fin)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic setup(input int c, input logic [31:0] s, input logic [31:0] d,
                       input int cnt, input bit b4, input logic [1:0] w,
                       input logic [1:0] ss, input logic [1:0] ds,
                       input logic [3:0] shs, input logic [3:0] dhs, input bit fen);
    rf_src[c] = s; rf_dst[c] = d; rf_cnt[c] = CW'(cnt); rf_b4[c] = b4;
    rf_wid[c] = w; rf_ss[c] = ss; rf_ds[c] = ds; rf_shs[c] = shs; rf_dhs[c] = dhs;
    rf_fen[c] = fen; rf_fin[c] = 1'b0;
  endtask

  task automatic wait_done(input logic [3:0] mask, input string tag);
    int guard = 0;
    while (((rf_st[0] && mask[0]) || (rf_st[1] && mask[1]) ||
            (rf_st[2] && mask[2]) || (rf_st[3] && mask[3])) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " completes"}, 32'(guard < 3000), 32'd1);
  endtask

  task automatic t_reset();
    check("R12 dack after reset", 32'(dack), 32'd0);
    check("R12 mem_req after reset", 32'(mem_req), 32'd0);
    check("R12 wb_valid after reset", 32'(wb_valid), 32'd0);
  endtask

  task automatic t_incr_burst();
    int rd0, wr0, g;
    bit ok = 1;
    setup(0, 32'h100, 32'h200, 8, 1, 2'd2, 2'd1, 2'd1, 4'd0, 4'd0, 1);
    rd0 = rd_n; wr0 = wr_n;
    rf_st[0] = 1'b1;
    g = 0;
    while (!(mem_req && mem_we) && g < 200) begin @(negedge clk); g++; end
    check("R4 reads before first write", 32'(rd_n - rd0), 32'd4);
    wait_done(4'b0001, "R3 ch0");
    for (int i = 0; i < 32; i++) if (mem[10'h200 + 10'(i)] !== mem[10'h100 + 10'(i)]) ok = 0;
    check("R7 incrementing copy data", 32'(ok), 32'd1);
    check("R3 reads", 32'(rd_n - rd0), 32'd8);
    check("R3 writes", 32'(wr_n - wr0), 32'd8);
    check("R3 final count", 32'(rf_cnt[0]), 32'd0);
    check("R9 final src", rf_src[0], 32'h120);
    check("R9 final dst", rf_dst[0], 32'h220);
    check("R8 finish flag set", 32'(rf_fin[0]), 32'd1);
  endtask

  task automatic t_partial_burst();
    int wb0 = wb_n;
    setup(1, 32'h140, 32'h300, 6, 1, 2'd1, 2'd1, 2'd1, 4'd0, 4'd0, 0);
    rf_st[1] = 1'b1;
    wait_done(4'b0010, "R3 ch1");
    check("R3 two bursts for six elements", 32'(wb_n - wb0), 32'd2);
    check("R7 halfword dst advance", rf_dst[1], 32'h30C);
    check("R7 last halfword copied", 32'(mem[10'h30B]), 32'(mem[10'h14B]));
    check("R8 no finish flag when disabled", 32'(rf_fin[1]), 32'd0);
  endtask

  task automatic t_fixed_stride();
    mem[10'h180] = 8'h5A;
    for (int i = 0; i < 8; i++) mem[10'h400 + 10'(i)] = 8'h00;
    setup(2, 32'h180, 32'h400, 3, 0, 2'd0, 2'd0, 2'd2, 4'd0, 4'd0, 1);
    rf_st[2] = 1'b1;
    wait_done(4'b0100, "R7 ch2");
    check("R7 byte at 0x400", 32'(mem[10'h400]), 32'h5A);
    check("R7 byte at 0x402", 32'(mem[10'h402]), 32'h5A);
    check("R7 byte at 0x404", 32'(mem[10'h404]), 32'h5A);
    check("R7 gap byte untouched", 32'(mem[10'h401]), 32'h00);
    check("R9 fixed src kept", rf_src[2], 32'h180);
    check("R9 strided dst final", rf_dst[2], 32'h406);
  endtask

  task automatic t_handshake();
    int rd0, g;
    setup(1, 32'h100, 32'h500, 2, 0, 2'd2, 2'd1, 2'd1, 4'd3, 4'd5, 0);
    dreq[5] = 1'b1; dreq[3] = 1'b0;
    rd0 = rd_n;
    rf_st[1] = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 postponed while src request low", 32'(rd_n - rd0), 32'd0);
    check("R2 channel still started", 32'(rf_st[1]), 32'd1);
    dreq[3] = 1'b1;
    g = 0;
    while (!(mem_req && mem_we) && g < 200) begin @(negedge clk); g++; end
    check("R5 src ack after read phase", 32'(dack[3]), 32'd1);
    check("R5 dst ack not before write", 32'(dack[5]), 32'd0);
    repeat (20) @(negedge clk);
    check("R2 held acks block next burst", 32'(rf_cnt[1]), 32'd1);
    check("R5 dst ack after write phase", 32'(dack[5]), 32'd1);
    check("R6 src ack held with request", 32'(dack[3]), 32'd1);
    dreq[3] = 1'b0; dreq[5] = 1'b0;
    @(negedge clk);
    check("R6 acks drop after request", 32'(dack[5:3]), 32'd0);
    dreq[3] = 1'b1; dreq[5] = 1'b1;
    wait_done(4'b0010, "R2 ch1");
    check("R9 handshake dst final", rf_dst[1], 32'h508);
    dreq[3] = 1'b0; dreq[5] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_priority();
    int base;
    setup(0, 32'h100, 32'h600, 1, 0, 2'd2, 2'd1, 2'd1, 4'd6, 4'd0, 0);
    setup(2, 32'h104, 32'h610, 1, 0, 2'd2, 2'd1, 2'd1, 4'd0, 4'd0, 0);
    setup(3, 32'h108, 32'h620, 1, 0, 2'd2, 2'd1, 2'd1, 4'd0, 4'd0, 0);
    dreq[6] = 1'b0;
    base = wb_n;
    rf_st[0] = 1'b1; rf_st[2] = 1'b1; rf_st[3] = 1'b1;
    wait_done(4'b1100, "R10 ch2 ch3");
    check("R1 lower ready channel first", 32'(wb_log[base % 64]), 32'd2);
    check("R1 next channel second", 32'(wb_log[(base + 1) % 64]), 32'd3);
    check("R10 blocked channel still pending", 32'(rf_st[0]), 32'd1);
    dreq[6] = 1'b1;
    wait_done(4'b0001, "R10 ch0 retried");
    check("R10 ch0 data", 32'(mem[10'h600]), 32'(mem[10'h100]));
    dreq[6] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_zero();
    int rd0 = rd_n, wr0 = wr_n;
    setup(3, 32'h100, 32'h700, 0, 1, 2'd2, 2'd1, 2'd1, 4'd0, 4'd0, 1);
    rf_st[3] = 1'b1;
    wait_done(4'b1000, "R11 ch3");
    check("R11 no reads", 32'(rd_n - rd0), 32'd0);
    check("R11 no writes", 32'(wr_n - wr0), 32'd0);
    check("R11 R8 finish flag", 32'(rf_fin[3]), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    dreq = '0; mem_ready = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      rf_st[c] = 0;
      setup(c, 0, 0, 0, 0, 2'd0, 2'd0, 2'd0, 4'd0, 4'd0, 0);
    end
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_incr_burst();
    t_partial_burst();
    t_fixed_stride();
    t_handshake();
    t_priority();
    t_zero();
    summary();
  end
endmodule